// File: doc/BRIEF.md
# Interleaved Burst Channel Router

This block sits behind a receive user interface on which packet data arrives in bursts, and bursts that belong to different logical channels may be interleaved beat by beat. Each input beat carries four 64-bit words, a 3-bit count of valid words, burst-start, burst-end and packet-start flags, a 4-bit end-of-packet code and an 8-bit channel number. The channel number means something only on a burst-start beat. The block captures it there and applies it to every following beat of the same burst.

Every accepted beat leaves the block one cycle later as a tagged output beat. The output beat carries the held channel, the data with the unused words cleared, the word count, packet-start and packet-end markers and the byte count of the last word. The block keeps one open-packet flag per channel. It uses these flags, together with the burst state, to raise a one-cycle error pulse that carries an error kind and the channel concerned. A packet may be split over several bursts, and bursts of other channels may arrive between them. The block never stalls, because the input interface has no way to push back.

Top module: `ilv_burst_router`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `err_valid` and all other outputs are 0, no channel has an open packet and no burst is in progress.
- R2: A beat with `in_nvalid` = 0 is idle and is ignored whatever its flags say: no output beat, no error, and no change to the held channel, the burst state or any open-packet flag.
- R3: An accepted beat appears on the outputs exactly one clock later with `out_valid` = 1. `out_chan` is the channel sampled on the burst-start beat of its burst, even if `in_chan` changes during the rest of the burst.
- R4: Word i occupies data bits [64i+63:64i], and word 3 is at the top. For a count n in 1..4, words 3 down to 4-n are passed through and the lower words are output as zero. A count of 5 to 7 is treated as 4.
- R5: `out_sop` = 1 exactly when the beat has both burst-start and packet-start set. A beat with burst-start and burst-end both set forms a complete one-beat burst.
- R6: End-of-packet code bit 3 = 1 marks the last beat of a packet and drives `out_eop` = 1. `out_lastbytes` then equals code bits [2:0], or 8 when those bits are 0. When code bit 3 = 0, `out_eop` and `out_lastbytes` are 0.
- R7: A channel's open-packet flag is set by packet-start and cleared by end of packet. A burst that ends without end of packet leaves the packet open, and the channel may resume it with a burst-start beat without packet-start after any number of bursts on other channels, with no error.
- R8: A packet-start beat on a channel whose packet is still open raises an error of kind 1 on that channel. The beat is still forwarded and the packet restarts.
- R9: A burst-start beat without packet-start on a channel with no open packet raises an error of kind 2 on that channel. The beat is forwarded with `out_sop` = 0.
- R10: A data beat without burst-start while no burst is in progress raises an error of kind 3. That error reports the last held channel, and the beat is dropped.
- R11: A data beat whose effective channel is not below the channel count raises an error of kind 0 on that channel, is dropped, and leaves all open-packet flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_sob | input | 1 | Burst start |
| in_eob | input | 1 | Burst end |
| in_sop | input | 1 | Packet start (with burst start) |
| in_nvalid | input | 3 | Number of valid words, 0 = idle |
| in_eopcode | input | 4 | Bit 3 end of packet, bits 2:0 bytes in last word |
| in_chan | input | 8 | Channel, meaningful on burst start only |
| in_data | input | 256 | Four 64-bit words, first word on top |
| out_valid | output | 1 | Output beat valid |
| out_chan | output | 8 | Channel of the beat |
| out_data | output | 256 | Data with invalid words cleared |
| out_nvalid | output | 3 | Valid word count, 1 to 4 |
| out_sop | output | 1 | Packet start |
| out_eop | output | 1 | Packet end |
| out_lastbytes | output | 4 | Valid bytes in last word when out_eop, else 0 |
| err_valid | output | 1 | Error pulse |
| err_kind | output | 2 | 0 range, 1 duplicate start, 2 orphan burst, 3 outside burst |
| err_chan | output | 8 | Channel the error concerns |

## Verification
The bench aims first at the held channel. It changes `in_chan` on continuation beats, so a design that sampled the channel on every beat would send data to the wrong stream. It sends idle beats that carry set flags, which catches a design that qualifies state updates with the flags alone and not with the word count. It interleaves bursts of several channels and lets one packet resume after another channel's burst, so a design that keeps a single global packet flag would report false errors or miss real ones. Other cases cover word counts above four, the end code whose byte field is zero (8 bytes), and channels outside the table. A design that clamped, decoded or range-checked these wrongly would produce wrong masks, byte counts or corrupted flags.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

  typedef enum logic [1:0] {
    ERR_RANGE   = 2'd0,
    ERR_DUP_SOP = 2'd1,
    ERR_ORPHAN  = 2'd2,
    ERR_OUTSIDE = 2'd3
  } err_kind_t;

  // bytes held by the final word: a zero field means the whole 8-byte word
  function automatic logic [3:0] last_word_bytes(input logic [2:0] low);
    return (low == 3'd0) ? 4'd8 : {1'b0, low};
  endfunction

endpackage

// File: rtl/ibr_burst_tracker.sv
module ibr_burst_tracker #(
  parameter int CHAN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live,
  input  logic              sob,
  input  logic              eob,
  input  logic [CHAN_W-1:0] chan_in,
  output logic [CHAN_W-1:0] cur_chan,
  output logic [CHAN_W-1:0] held_chan,
  output logic              in_burst_q,
  output logic              outside
);

  logic [CHAN_W-1:0] held_q;
  logic              burst_d;

  assign held_chan = held_q;
  assign cur_chan  = sob ? chan_in : held_q;
  assign outside   = live && !sob && !in_burst_q;

  always_comb begin
    burst_d = in_burst_q;
    if (live) begin
      if (sob)             burst_d = !eob;
      else if (in_burst_q) burst_d = !eob;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q     <= '0;
      in_burst_q <= 1'b0;
    end else begin
      in_burst_q <= burst_d;
      if (live && sob) held_q <= chan_in;
    end
  end

endmodule

// File: rtl/ibr_open_table.sv
module ibr_open_table #(
  parameter int NUM_CHAN = 16,
  parameter int IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    idx,
  input  logic                set_en,
  input  logic                clr_en,
  output logic                open_rd,
  output logic [NUM_CHAN-1:0] open_vec
);

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_flag
    logic hit;
    assign hit = (idx == IDX_W'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                open_vec[c] <= 1'b0;
      else if (clr_en && hit)    open_vec[c] <= 1'b0;
      else if (set_en && hit)    open_vec[c] <= 1'b1;
    end
  end

  assign open_rd = open_vec[idx];

endmodule

// File: rtl/ibr_beat_shaper.sv
module ibr_beat_shaper #(
  parameter int WORDS  = 4,
  parameter int WORD_W = 64,
  parameter int CNT_W  = 3,
  parameter int CHAN_W = 8,
  parameter int LB_W   = 4,
  localparam int DATA_W = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd,
  input  logic [CHAN_W-1:0] chan,
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  nvalid,
  input  logic              sop,
  input  logic              eop,
  input  logic [LB_W-1:0]   lastbytes,
  input  logic              err_fire,
  input  logic [1:0]        err_kind_in,
  input  logic [CHAN_W-1:0] err_chan_in,
  output logic              out_valid,
  output logic [CHAN_W-1:0] out_chan,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  out_nvalid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [LB_W-1:0]   out_lastbytes,
  output logic              err_valid,
  output logic [1:0]        err_kind,
  output logic [CHAN_W-1:0] err_chan
);

  function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] n);
    return (n > CNT_W'(WORDS)) ? CNT_W'(WORDS) : n;
  endfunction

  // valid words are packed from the top word downward
  function automatic logic [WORDS-1:0] top_mask(input logic [CNT_W-1:0] n);
    logic [WORDS-1:0] m;
    for (int w = 0; w < WORDS; w++) m[w] = (w >= WORDS - int'(n));
    return m;
  endfunction

  logic [CNT_W-1:0]  cnt_c;
  logic [WORDS-1:0]  keep_c;
  logic [DATA_W-1:0] data_c;

  assign cnt_c  = clamp_count(nvalid);
  assign keep_c = top_mask(cnt_c);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign data_c[w*WORD_W +: WORD_W] = keep_c[w] ? data[w*WORD_W +: WORD_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_chan      <= '0;
      out_data      <= '0;
      out_nvalid    <= '0;
      out_sop       <= 1'b0;
      out_eop       <= 1'b0;
      out_lastbytes <= '0;
      err_valid     <= 1'b0;
      err_kind      <= '0;
      err_chan      <= '0;
    end else begin
      out_valid     <= fwd;
      out_chan      <= fwd ? chan : '0;
      out_data      <= fwd ? data_c : '0;
      out_nvalid    <= fwd ? cnt_c : '0;
      out_sop       <= fwd && sop;
      out_eop       <= fwd && eop;
      out_lastbytes <= (fwd && eop) ? lastbytes : '0;
      err_valid     <= err_fire;
      err_kind      <= err_fire ? err_kind_in : '0;
      err_chan      <= err_fire ? err_chan_in : '0;
    end
  end

endmodule

// File: rtl/ilv_burst_router.sv
module ilv_burst_router #(
  parameter int NUM_CHAN = 16,
  parameter int CHAN_W   = 8,
  parameter int WORDS    = 4,
  parameter int WORD_W   = 64,
  parameter int CNT_W    = 3,
  parameter int CODE_W   = 4,
  localparam int DATA_W  = WORDS * WORD_W,
  localparam int IDX_W   = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_sob,
  input  logic              in_eob,
  input  logic              in_sop,
  input  logic [CNT_W-1:0]  in_nvalid,
  input  logic [CODE_W-1:0] in_eopcode,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [CHAN_W-1:0] out_chan,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  out_nvalid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [CODE_W-1:0] out_lastbytes,
  output logic              err_valid,
  output logic [1:0]        err_kind,
  output logic [CHAN_W-1:0] err_chan
);
  import ibr_pkg::*;

  localparam logic [CHAN_W:0] CHAN_LIM = (CHAN_W+1)'(NUM_CHAN);

  logic              live;
  logic [CHAN_W-1:0] cur_chan, held_chan;
  logic              in_burst_q, outside;
  logic              chan_ok, range_bad, ok_beat;
  logic              dup_sop, orphan, err_fire;
  err_kind_t         kind_c;
  logic [CHAN_W-1:0] err_chan_c;
  logic [IDX_W-1:0]  tbl_idx;
  logic              set_en, clr_en, open_rd;
  logic [NUM_CHAN-1:0] open_vec;
  logic              eop_flag;
  logic [CODE_W-1:0] lastbytes_c;

  assign live = (in_nvalid != '0);

  ibr_burst_tracker #(.CHAN_W(CHAN_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .live      (live),
    .sob       (in_sob),
    .eob       (in_eob),
    .chan_in   (in_chan),
    .cur_chan  (cur_chan),
    .held_chan (held_chan),
    .in_burst_q(in_burst_q),
    .outside   (outside)
  );

  assign chan_ok   = ({1'b0, cur_chan} < CHAN_LIM);
  assign range_bad = live && !outside && !chan_ok;
  assign ok_beat   = live && !outside && chan_ok;
  assign tbl_idx   = cur_chan[IDX_W-1:0];

  assign dup_sop = ok_beat && in_sob && in_sop && open_rd;
  assign orphan  = ok_beat && in_sob && !in_sop && !open_rd;
  assign err_fire = outside || range_bad || dup_sop || orphan;

  always_comb begin
    kind_c     = ERR_RANGE;
    err_chan_c = cur_chan;
    if (outside) begin
      kind_c     = ERR_OUTSIDE;
      err_chan_c = held_chan;
    end else if (range_bad) kind_c = ERR_RANGE;
    else if (dup_sop)       kind_c = ERR_DUP_SOP;
    else if (orphan)        kind_c = ERR_ORPHAN;
  end

  assign eop_flag    = in_eopcode[CODE_W-1];
  assign lastbytes_c = last_word_bytes(in_eopcode[2:0]);
  assign set_en      = ok_beat && in_sob && in_sop;
  assign clr_en      = ok_beat && eop_flag;

  ibr_open_table #(.NUM_CHAN(NUM_CHAN), .IDX_W(IDX_W)) u_open (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (tbl_idx),
    .set_en  (set_en),
    .clr_en  (clr_en),
    .open_rd (open_rd),
    .open_vec(open_vec)
  );

  ibr_beat_shaper #(
    .WORDS(WORDS), .WORD_W(WORD_W), .CNT_W(CNT_W), .CHAN_W(CHAN_W), .LB_W(CODE_W)
  ) u_shape (
    .clk          (clk),
    .rst_n        (rst_n),
    .fwd          (ok_beat),
    .chan         (cur_chan),
    .data         (in_data),
    .nvalid       (in_nvalid),
    .sop          (in_sob && in_sop),
    .eop          (eop_flag),
    .lastbytes    (lastbytes_c),
    .err_fire     (err_fire),
    .err_kind_in  (kind_c),
    .err_chan_in  (err_chan_c),
    .out_valid    (out_valid),
    .out_chan     (out_chan),
    .out_data     (out_data),
    .out_nvalid   (out_nvalid),
    .out_sop      (out_sop),
    .out_eop      (out_eop),
    .out_lastbytes(out_lastbytes),
    .err_valid    (err_valid),
    .err_kind     (err_kind),
    .err_chan     (err_chan)
  );

endmodule

// File: rtl/ibr_checker.sv
module ibr_checker #(
  parameter int NUM_CHAN = 16,
  parameter int WORDS    = 4,
  parameter int CNT_W    = 3,
  parameter int IDX_W    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CNT_W-1:0]    in_nvalid,
  input logic                in_sob,
  input logic                in_burst_q,
  input logic                set_en,
  input logic                clr_en,
  input logic [IDX_W-1:0]    tbl_idx,
  input logic [NUM_CHAN-1:0] open_vec,
  input logic                out_valid,
  input logic [CNT_W-1:0]    out_nvalid,
  input logic                out_eop,
  input logic [3:0]          out_lastbytes,
  input logic                err_valid,
  input logic [1:0]          err_kind
);
  import ibr_pkg::*;

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_nvalid == '0) |=> (!out_valid && !err_valid)); // R2

  AST_IDLE_KEEPS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_nvalid == '0) |=> $stable(in_burst_q)); // R2

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_nvalid != '0 && out_nvalid <= CNT_W'(WORDS))); // R4

  AST_LASTBYTES_ONLY_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    !out_eop |-> (out_lastbytes == 4'd0)); // R6

  AST_LASTBYTES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> (out_lastbytes != 4'd0 && out_lastbytes <= 4'd8)); // R6

  AST_OPEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> open_vec[$past(tbl_idx)]); // R7

  AST_OPEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !open_vec[$past(tbl_idx)]); // R7

  AST_FWD_ERR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && err_valid) |-> (err_kind == ERR_DUP_SOP || err_kind == ERR_ORPHAN)); // R8

  AST_OUTSIDE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_nvalid != '0 && !in_sob && !in_burst_q) |=> (err_valid && err_kind == ERR_OUTSIDE && !out_valid)); // R10

endmodule

bind ilv_burst_router ibr_checker #(
  .NUM_CHAN(NUM_CHAN), .WORDS(WORDS), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_nvalid    (in_nvalid),
  .in_sob       (in_sob),
  .in_burst_q   (in_burst_q),
  .set_en       (set_en),
  .clr_en       (clr_en),
  .tbl_idx      (tbl_idx),
  .open_vec     (open_vec),
  .out_valid    (out_valid),
  .out_nvalid   (out_nvalid),
  .out_eop      (out_eop),
  .out_lastbytes(out_lastbytes),
  .err_valid    (err_valid),
  .err_kind     (err_kind)
);

// File: tb/ilv_burst_router_test.sv
`timescale 1ns/1ps
module ilv_burst_router_test;
  localparam int NCH = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_sob = 0, in_eob = 0, in_sop = 0;
  logic [2:0]   in_nvalid = 0;
  logic [3:0]   in_eopcode = 0;
  logic [7:0]   in_chan = 0;
  logic [255:0] in_data = '0;
  logic         out_valid, out_sop, out_eop, err_valid;
  logic [7:0]   out_chan, err_chan;
  logic [255:0] out_data;
  logic [2:0]   out_nvalid;
  logic [3:0]   out_lastbytes;
  logic [1:0]   err_kind;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  logic [7:0]     m_held = 0;
  logic           m_burst = 0;
  logic [NCH-1:0] m_open = '0;

  always #4 clk = ~clk;

  ilv_burst_router uut (
    .clk(clk), .rst_n(rst_n), .in_sob(in_sob), .in_eob(in_eob), .in_sop(in_sop),
    .in_nvalid(in_nvalid), .in_eopcode(in_eopcode), .in_chan(in_chan), .in_data(in_data),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data), .out_nvalid(out_nvalid),
    .out_sop(out_sop), .out_eop(out_eop), .out_lastbytes(out_lastbytes),
    .err_valid(err_valid), .err_kind(err_kind), .err_chan(err_chan)
  );

  task automatic chk(input string tag, input string what, input logic [255:0] act,
                     input logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_bytes(input logic [3:0] code);
    if (!code[3]) return 4'd0;
    return (code[2:0] == 3'd0) ? 4'd8 : {1'b0, code[2:0]};
  endfunction

  function automatic logic [255:0] exp_words(input logic [255:0] d, input int k);
    logic [255:0] r = '0;
    for (int w = 0; w < 4; w++) if (w >= 4 - k) r[w*64 +: 64] = d[w*64 +: 64];
    return r;
  endfunction

  function automatic string kind_tag(input logic e, input logic [1:0] k);
    if (!e) return "R7";
    case (k)
      2'd0: return "R11";
      2'd1: return "R8";
      2'd2: return "R9";
      default: return "R10";
    endcase
  endfunction

  // drive one beat at a falling edge, check the registered result one cycle later
  task automatic beat(input logic sob, input logic eob, input logic sop, input logic [2:0] nv,
                      input logic [3:0] code, input logic [7:0] ch, input logic [255:0] d);
    logic ev = 0, esop = 0, eeop = 0, ee = 0;
    logic [7:0] ech = 0, eech = 0, cur;
    logic [2:0] env = 0;
    logic [1:0] ek = 0;
    logic [255:0] ed = '0;
    logic [3:0] elb = 0;
    int k;
    in_sob = sob; in_eob = eob; in_sop = sop; in_nvalid = nv;
    in_eopcode = code; in_chan = ch; in_data = d;
    if (nv != 0) begin
      cur = sob ? ch : m_held;
      if (!sob && !m_burst) begin
        ee = 1; ek = 2'd3; eech = m_held;
      end else if (cur >= NCH) begin
        ee = 1; ek = 2'd0; eech = cur;
      end else begin
        k = (nv > 4) ? 4 : int'(nv);
        ev = 1; ech = cur; env = 3'(k); ed = exp_words(d, k);
        esop = sob && sop; eeop = code[3]; elb = exp_bytes(code);
        if (sob && sop && m_open[cur[3:0]])   begin ee = 1; ek = 2'd1; eech = cur; end
        if (sob && !sop && !m_open[cur[3:0]]) begin ee = 1; ek = 2'd2; eech = cur; end
        if (sob && sop) m_open[cur[3:0]] = 1'b1;
        if (code[3])    m_open[cur[3:0]] = 1'b0;
      end
      if (sob) begin m_held = ch; m_burst = !eob; end
      else if (m_burst) m_burst = !eob;
    end
    @(negedge clk);
    chk((nv == 0) ? "R2" : "R3", "out_valid", 256'(out_valid), 256'(ev));
    chk("R3", "out_chan", 256'(out_chan), 256'(ech));
    chk("R4", "out_data", out_data, ed);
    chk("R4", "out_nvalid", 256'(out_nvalid), 256'(env));
    chk("R5", "out_sop", 256'(out_sop), 256'(esop));
    chk("R6", "out_eop", 256'(out_eop), 256'(eeop));
    chk("R6", "out_lastbytes", 256'(out_lastbytes), 256'(elb));
    chk(kind_tag(ee, ek), "err_valid", 256'(err_valid), 256'(ee));
    chk(kind_tag(ee, ek), "err_kind", 256'(err_kind), 256'(ek));
    chk(kind_tag(ee, ek), "err_chan", 256'(err_chan), 256'(eech));
  endtask

  function automatic logic [255:0] rnd_data();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1", "out_valid in reset", 256'(out_valid), 256'd0);
    chk("R1", "err_valid in reset", 256'(err_valid), 256'd0);
    chk("R1", "out_data in reset", out_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", 256'(out_valid), 256'd0);
    // R1: no open packet after reset, so a resume burst is an orphan (R9)
    beat(1, 1, 0, 3'd4, 4'h0, 8'd1, rnd_data());
    // R3: packet on channel 2, continuation carries a bogus channel
    beat(1, 0, 1, 3'd4, 4'h0, 8'd2, rnd_data());
    beat(0, 1, 0, 3'd4, 4'h0, 8'd9, rnd_data());
    // R5 R6: single-beat packet on channel 4, three words, three bytes
    beat(1, 1, 1, 3'd3, 4'hB, 8'd4, rnd_data());
    // R2: idle beat with every flag set must not disturb anything
    beat(1, 1, 1, 3'd0, 4'h8, 8'd2, rnd_data());
    // R7: channel 2 resumes its open packet, no error
    beat(1, 1, 0, 3'd2, 4'h0, 8'd2, rnd_data());
    // R8: packet start while channel 2 still open
    beat(1, 0, 1, 3'd1, 4'h0, 8'd2, rnd_data());
    // R6: end code with zero byte field means 8 bytes; R4 count 6 clamps to 4
    beat(0, 1, 0, 3'd6, 4'h8, 8'd0, rnd_data());
    // R10: data beat outside any burst
    beat(0, 0, 0, 3'd2, 4'h0, 8'd3, rnd_data());
    // R11: out-of-range channel, two beats of one burst
    beat(1, 0, 1, 3'd4, 4'h0, 8'd17, rnd_data());
    beat(0, 1, 0, 3'd4, 4'h9, 8'd1, rnd_data());
    // R4: each count value once
    for (int n = 1; n <= 7; n++) beat(1, 1, 1, 3'(n), 4'h8, 8'd5, rnd_data());
    // constrained random interleaving
    for (int i = 0; i < 600; i++) begin
      logic s = ($urandom % 100) < 45;
      logic e = ($urandom % 100) < 40;
      logic p = ($urandom % 100) < 50;
      logic [2:0] nv = ($urandom % 10 == 0) ? 3'd0 : 3'($urandom % 8);
      logic [3:0] cd = ($urandom % 100) < 30 ? {1'b1, 3'($urandom)} : {1'b0, 3'($urandom % 2)};
      logic [7:0] c = ($urandom % 12 == 0) ? 8'(16 + $urandom % 240) : 8'($urandom % 6);
      beat(s, e, p, nv, cd, c, rnd_data());
    end
    in_nvalid = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired before the stimulus finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule